// File: doc/BRIEF.md
# Cache Flush and Sync Sequencer

This block is the maintenance engine for a second-level cache's tag/state array. Two active-low request inputs start one of two walks over every line index. A **flush** walk empties both cache levels. For each line it sends an inquire with back-invalidation to the upstream first-level cache, writes the line back to main memory if it holds modified data, and then marks the line invalid. A **sync** walk cleans the cache but keeps its contents. It sends a plain inquire, writes back modified data, and turns each modified line into exclusive. Exclusive, shared and invalid lines are left alone.

The engine reads and writes line state through a simple array port; the array itself is outside the block and reads combinationally at the presented index. Upstream inquires and memory write-backs each use a request/acknowledge handshake. The inquire acknowledge carries a flag that reports whether the upstream cache held modified data for the line. That data is folded in before the line's own write-back decision is made. The block moves no data and has no part in the memory bus protocol. It only orders the steps.

Top module: `l2_maint_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `busy`, `done`, `inq_req`, `wb_req` and `st_wr_en` are low.
- R2: While idle, a high-to-low transition on `flush_n` or `sync_n` starts a walk, and `busy` is high in the cycle after the edge is sampled. A request held low after a walk does not start another walk.
- R3: If both requests fall in the same cycle, a flush walk runs (`mode_flush` = 1).
- R4: A request edge that arrives while `busy` is high is ignored. The running mode does not change and only one `done` pulse follows.
- R5: A walk visits indices 0 to LINES-1 in ascending order and issues exactly one inquire per index.
- R6: `inq_req` and `wb_req` stay high, with `st_idx` unchanged, until the matching acknowledge is seen.
- R7: For each line, the inquire completes before any write-back of that line. A write-back is issued exactly when the line's state reads modified, or when `inq_mod` is high with `inq_ack`. The state encoding is I=0, S=1, E=2, M=3.
- R8: In a flush walk every inquire has `inq_inval` = 1, and every line ends in state I (0).
- R9: In a sync walk every inquire has `inq_inval` = 0. Lines that needed a write-back end in state E (2), and all other lines keep their previous state.
- R10: `done` is high for exactly one cycle at the end of a walk, `busy` is high in that cycle, and `busy` is high from the start of the walk until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_n | input | 1 | Active-low flush request, edge-triggered |
| sync_n | input | 1 | Active-low sync request, edge-triggered |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| mode_flush | output | 1 | Mode of the current or last walk: 1 flush, 0 sync |
| st_idx | output | IDX_W | Line index for the state array, write-back and inquire |
| st_rd_state | input | 2 | State of line `st_idx` read from the array |
| st_wr_en | output | 1 | Write `st_wr_state` to line `st_idx` |
| st_wr_state | output | 2 | New line state |
| inq_req | output | 1 | Inquire request to the upstream cache |
| inq_inval | output | 1 | Inquire also back-invalidates the upstream copy |
| inq_ack | input | 1 | Inquire acknowledge |
| inq_mod | input | 1 | With `inq_ack`: the upstream cache held modified data |
| wb_req | output | 1 | Write-back request for line `st_idx` |
| wb_ack | input | 1 | Write-back acknowledge |

## Verification
On every cycle, the assertions check the handshake holds, that no inquire and write-back are requested at once, that state writes carry the value the mode demands, that the mode is stable through a walk, that the engine is quiet while idle, and the shape of the done pulse. Several properties cover the whole walk and can only be shown by the bench's scenarios: the ascending visit order, one inquire per line, the inquire-before-write-back order for each line, the exact number of write-backs including lines made dirty by the upstream cache, and the final state of every line. The same holds for the edge-only start, the flush priority and the ignoring of requests while busy. The bench checks each of these against a line-state model computed from the loaded pattern.

// File: rtl/l2m_pkg.sv
// Package: shared types for the cache maintenance sequencer.
// Assumes a two-bit line state encoding I=0, S=1, E=2, M=3.
package l2m_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_t;

    typedef enum logic [2:0] {
        WK_IDLE = 3'd0,
        WK_LOOK = 3'd1,
        WK_INQ  = 3'd2,
        WK_WB   = 3'd3,
        WK_UPD  = 3'd4,
        WK_FIN  = 3'd5
    } walk_st_t;

endpackage

// File: rtl/l2m_req_arb.sv
// Module: request edge detector and arbiter.
// Turns the active-low flush and sync levels into a single start pulse while
// idle; flush wins when both fall together. Assumes both inputs are already
// synchronous to clk. Edges seen while not idle are dropped.
module l2m_req_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_n,
    input  logic sync_n,
    input  logic idle,
    output logic start,
    output logic start_flush
);

    logic prev_flush_n;
    logic prev_sync_n;
    logic flush_fall;
    logic sync_fall;

    // Remember last cycle's request levels; reset treats both as released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_flush_n <= 1'b1;
            prev_sync_n  <= 1'b1;
        end else begin
            prev_flush_n <= flush_n;
            prev_sync_n  <= sync_n;
        end
    end

    // Detect falling edges and apply flush priority while idle.
    always_comb begin
        flush_fall  = prev_flush_n & ~flush_n;
        sync_fall   = prev_sync_n & ~sync_n;
        start       = idle & (flush_fall | sync_fall);
        start_flush = idle & flush_fall;
    end

endmodule

// File: rtl/l2m_line_ctr.sv
// Module: line index counter for the maintenance walk.
// Clears to zero at walk start, steps by one per finished line, and flags the
// final index. Assumes LINES >= 2.
module l2m_line_ctr #(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    // Hold the current line index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    // Flag the last line of the walk.
    always_comb begin
        last = (idx == LAST_IDX);
    end

endmodule

// File: rtl/l2m_walk_fsm.sv
// Module: per-line sequencing state machine.
// For each line: latch its state, inquire upstream (with back-invalidation in
// flush mode), write back if the line or the upstream copy is modified, then
// update the line state. Assumes the state array reads combinationally at the
// index held by the line counter, which stays stable for the whole line.
module l2m_walk_fsm
    import l2m_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_flush,
    input  logic       last,
    input  logic [1:0] rd_state,
    input  logic       inq_ack,
    input  logic       inq_mod,
    input  logic       wb_ack,
    output logic       idle,
    output logic       busy,
    output logic       done,
    output logic       mode_flush,
    output logic       clear,
    output logic       step,
    output logic       inq_req,
    output logic       inq_inval,
    output logic       wb_req,
    output logic       wr_en,
    output logic [1:0] wr_state
);

    walk_st_t st_q;
    walk_st_t st_d;
    line_st_t line_q;
    logic     dirty_q;
    logic     dirty_now;

    // Dirty if the line itself is modified or the upstream reported modified data.
    always_comb begin
        dirty_now = (line_q == LS_MOD) | inq_mod;
    end

    // Next-state selection for the walk.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WK_IDLE: if (start) st_d = WK_LOOK;
            WK_LOOK: st_d = WK_INQ;
            WK_INQ:  if (inq_ack) st_d = dirty_now ? WK_WB : WK_UPD;
            WK_WB:   if (wb_ack) st_d = WK_UPD;
            WK_UPD:  st_d = last ? WK_FIN : WK_LOOK;
            WK_FIN:  st_d = WK_IDLE;
            default: st_d = WK_IDLE;
        endcase
    end

    // State register, walk mode, latched line state and dirty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= WK_IDLE;
            mode_flush <= 1'b0;
            line_q     <= LS_INV;
            dirty_q    <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == WK_IDLE && start) begin
                mode_flush <= start_flush;
            end
            if (st_q == WK_LOOK) begin
                line_q  <= line_st_t'(rd_state);
                dirty_q <= 1'b0;
            end
            if (st_q == WK_INQ && inq_ack) begin
                dirty_q <= dirty_now;
            end
        end
    end

    // Decode outputs from the current walk state.
    always_comb begin
        idle      = (st_q == WK_IDLE);
        busy      = ~idle;
        done      = (st_q == WK_FIN);
        clear     = idle & start;
        step      = (st_q == WK_UPD) & ~last;
        inq_req   = (st_q == WK_INQ);
        inq_inval = mode_flush;
        wb_req    = (st_q == WK_WB);
        wr_en     = (st_q == WK_UPD) & (mode_flush | dirty_q);
        wr_state  = mode_flush ? LS_INV : LS_EXC;
    end

endmodule

// File: rtl/l2_maint_seq.sv
// Module: cache flush and sync sequencer (top).
// Walks every line of a second-level cache state array on a flush or sync
// request, coordinating upstream inquires and memory write-backs. Assumes an
// external state array with combinational read at st_idx and write on st_wr_en.
module l2_maint_seq #(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_n,
    input  logic             sync_n,
    output logic             busy,
    output logic             done,
    output logic             mode_flush,
    output logic [IDX_W-1:0] st_idx,
    input  logic [1:0]       st_rd_state,
    output logic             st_wr_en,
    output logic [1:0]       st_wr_state,
    output logic             inq_req,
    output logic             inq_inval,
    input  logic             inq_ack,
    input  logic             inq_mod,
    output logic             wb_req,
    input  logic             wb_ack
);

    logic idle;
    logic start;
    logic start_flush;
    logic clear;
    logic step;
    logic last;

    l2m_req_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_n     (flush_n),
        .sync_n      (sync_n),
        .idle        (idle),
        .start       (start),
        .start_flush (start_flush)
    );

    l2m_line_ctr #(.LINES(LINES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (step),
        .idx   (st_idx),
        .last  (last)
    );

    l2m_walk_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_flush (start_flush),
        .last        (last),
        .rd_state    (st_rd_state),
        .inq_ack     (inq_ack),
        .inq_mod     (inq_mod),
        .wb_ack      (wb_ack),
        .idle        (idle),
        .busy        (busy),
        .done        (done),
        .mode_flush  (mode_flush),
        .clear       (clear),
        .step        (step),
        .inq_req     (inq_req),
        .inq_inval   (inq_inval),
        .wb_req      (wb_req),
        .wr_en       (st_wr_en),
        .wr_state    (st_wr_state)
    );

endmodule

// File: rtl/l2_maint_seq_chk.sv
// Module: assertion checker for the sequencer, bound to the top module.
// Observes ports only.
module l2_maint_seq_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             mode_flush,
    input logic [IDX_W-1:0] st_idx,
    input logic             st_wr_en,
    input logic [1:0]       st_wr_state,
    input logic             inq_req,
    input logic             inq_ack,
    input logic             wb_req,
    input logic             wb_ack
);

    // R1: engine is quiet in the cycle after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && !inq_req && !wb_req && !st_wr_en);

    // R2/R4: no activity outside a walk.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !inq_req && !wb_req && !st_wr_en && !done);

    // R4: mode does not change during a walk.
    assert_mode_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> $stable(mode_flush));

    // R6: inquire request held with index until acknowledged.
    assert_inq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inq_req && !inq_ack |=> inq_req && $stable(st_idx));

    // R6: write-back request held with index until acknowledged.
    assert_wb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req && $stable(st_idx));

    // R7: inquire and write-back never requested together.
    assert_one_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(inq_req && wb_req));

    // R8: flush writes only invalid.
    assert_flush_inv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en && mode_flush |-> st_wr_state == 2'd0);

    // R9: sync writes only exclusive.
    assert_sync_exc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en && !mode_flush |-> st_wr_state == 2'd2);

    // R10: done is one cycle long and inside busy.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy ##1 !done);

endmodule

bind l2_maint_seq l2_maint_seq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .mode_flush  (mode_flush),
    .st_idx      (st_idx),
    .st_wr_en    (st_wr_en),
    .st_wr_state (st_wr_state),
    .inq_req     (inq_req),
    .inq_ack     (inq_ack),
    .wb_req      (wb_req),
    .wb_ack      (wb_ack)
);

// File: tb/l2_maint_seq_bench.sv
// Bench: models the state array and both handshake partners, runs flush and
// sync walks over several line-state patterns and checks every line.
module l2_maint_seq_bench;

    localparam int LINES = 16;
    localparam int IDX_W = $clog2(LINES);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush_n = 1'b1;
    logic             sync_n = 1'b1;
    logic             busy, done, mode_flush;
    logic [IDX_W-1:0] st_idx;
    logic [1:0]       st_rd_state;
    logic             st_wr_en;
    logic [1:0]       st_wr_state;
    logic             inq_req, inq_inval, wb_req;
    logic             inq_ack = 1'b0;
    logic             inq_mod = 1'b0;
    logic             wb_ack = 1'b0;

    always #10 clk = ~clk;

    l2_maint_seq #(.LINES(LINES)) u_l2_maint_seq (
        .clk(clk), .rst_n(rst_n), .flush_n(flush_n), .sync_n(sync_n),
        .busy(busy), .done(done), .mode_flush(mode_flush),
        .st_idx(st_idx), .st_rd_state(st_rd_state),
        .st_wr_en(st_wr_en), .st_wr_state(st_wr_state),
        .inq_req(inq_req), .inq_inval(inq_inval), .inq_ack(inq_ack),
        .inq_mod(inq_mod), .wb_req(wb_req), .wb_ack(wb_ack)
    );

    // Pattern storage, array model and load control.
    logic [1:0] pat_st [LINES];
    logic       pat_up [LINES];
    logic [1:0] mem    [LINES];
    logic       load = 1'b0;
    logic       clr_mon = 1'b0;
    logic       exp_inval = 1'b0;

    assign st_rd_state = mem[st_idx];

    always @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < LINES; i++) mem[i] <= pat_st[i];
        end else if (st_wr_en) begin
            mem[st_idx] <= st_wr_state;
        end
    end

    // Handshake partners with index-dependent latency.
    int inq_wait = 0;
    int wb_wait = 0;
    always @(posedge clk) begin
        inq_ack <= 1'b0;
        inq_mod <= 1'b0;
        wb_ack  <= 1'b0;
        if (inq_req && !inq_ack) begin
            if (inq_wait >= int'(st_idx) % 3) begin
                inq_ack  <= 1'b1;
                inq_mod  <= pat_up[st_idx];
                inq_wait <= 0;
            end else inq_wait <= inq_wait + 1;
        end
        if (wb_req && !wb_ack) begin
            if (wb_wait >= int'(st_idx) % 2 + 1) begin
                wb_ack  <= 1'b1;
                wb_wait <= 0;
            end else wb_wait <= wb_wait + 1;
        end
    end

    // Protocol monitor.
    int inq_cnt, wb_cnt, order_err, wb_order_err, inval_err, done_cnt, done_busy_err;
    int last_inq;
    always @(posedge clk) begin
        if (clr_mon) begin
            inq_cnt <= 0; wb_cnt <= 0; order_err <= 0; wb_order_err <= 0;
            inval_err <= 0; done_cnt <= 0; done_busy_err <= 0; last_inq <= -1;
        end else begin
            if (inq_req && inq_ack) begin
                if (int'(st_idx) != inq_cnt) order_err <= order_err + 1;
                if (inq_inval != exp_inval) inval_err <= inval_err + 1;
                inq_cnt  <= inq_cnt + 1;
                last_inq <= int'(st_idx);
            end
            if (wb_req && wb_ack) begin
                if (int'(st_idx) != last_inq) wb_order_err <= wb_order_err + 1;
                wb_cnt <= wb_cnt + 1;
            end
            if (done) begin
                done_cnt <= done_cnt + 1;
                if (!busy) done_busy_err <= done_busy_err + 1;
            end
        end
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Load pattern k into the array model and clear the monitor.
    task automatic load_pattern(input int k);
        for (int i = 0; i < LINES; i++) begin
            pat_st[i] = 2'((i * 7 + k) % 4);
            pat_up[i] = (((i + k) % 5) == 0) && (pat_st[i] != 2'd0);
        end
        @(negedge clk); load = 1'b1; clr_mon = 1'b1;
        @(negedge clk); load = 1'b0; clr_mon = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (done_cnt == 0 && t < 20000) begin
            @(negedge clk); t++;
        end
        check(done_cnt != 0, "R10 walk finished", done_cnt, 1);
        repeat (6) @(negedge clk);
    endtask

    // Check results of a finished walk against the pattern.
    task automatic check_walk(input bit flush);
        int exp_wb = 0;
        check(mode_flush == flush, "R3 mode", int'(mode_flush), int'(flush));
        check(inq_cnt == LINES, "R5 inquire count", inq_cnt, LINES);
        check(order_err == 0, "R5 ascending order", order_err, 0);
        check(wb_order_err == 0, "R7 inquire before write-back", wb_order_err, 0);
        check(inval_err == 0, flush ? "R8 inval flag" : "R9 inval flag", inval_err, 0);
        check(done_cnt == 1, "R10 single done", done_cnt, 1);
        check(done_busy_err == 0, "R10 busy with done", done_busy_err, 0);
        check(!busy, "R10 busy low after done", int'(busy), 0);
        for (int i = 0; i < LINES; i++) begin
            bit dirty = (pat_st[i] == 2'd3) || pat_up[i];
            int exp_st;
            if (dirty) exp_wb++;
            exp_st = flush ? 0 : (dirty ? 2 : int'(pat_st[i]));
            check(int'(mem[i]) == exp_st, flush ? "R8 line state" : "R9 line state",
                  int'(mem[i]), exp_st);
        end
        check(wb_cnt == exp_wb, "R7 write-back count", wb_cnt, exp_wb);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !inq_req && !wb_req && !st_wr_en, "R1 reset outputs",
              int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !inq_req && !wb_req && !st_wr_en, "R1 after reset",
              int'(busy), 0);

        // Sync walks over several patterns (R2, R5, R6, R7, R9, R10).
        for (int k = 0; k < 3; k++) begin
            load_pattern(k);
            exp_inval = 1'b0;
            sync_n = 1'b0;
            @(negedge clk);
            check(busy, "R2 busy after sync edge", int'(busy), 1);
            repeat (2) @(negedge clk);
            sync_n = 1'b1;
            wait_done();
            check_walk(1'b0);
        end

        // Flush walks; request held low past done must not restart (R2, R8).
        for (int k = 3; k < 5; k++) begin
            load_pattern(k);
            exp_inval = 1'b1;
            flush_n = 1'b0;
            @(negedge clk);
            check(busy, "R2 busy after flush edge", int'(busy), 1);
            wait_done();
            repeat (10) @(negedge clk);
            check(!busy && done_cnt == 1, "R2 held request no restart", int'(busy), 0);
            flush_n = 1'b1;
            check_walk(1'b1);
        end

        // Both requests fall together: flush wins (R3).
        load_pattern(5);
        exp_inval = 1'b1;
        flush_n = 1'b0; sync_n = 1'b0;
        @(negedge clk);
        flush_n = 1'b1; sync_n = 1'b1;
        wait_done();
        check_walk(1'b1);

        // Flush edge during a sync walk is ignored (R4).
        load_pattern(6);
        exp_inval = 1'b0;
        sync_n = 1'b0;
        @(negedge clk);
        sync_n = 1'b1;
        repeat (15) @(negedge clk);
        check(busy, "R4 walk running at disturb", int'(busy), 1);
        flush_n = 1'b0;
        repeat (2) @(negedge clk);
        flush_n = 1'b1;
        wait_done();
        check(mode_flush == 1'b0, "R4 mode unchanged", int'(mode_flush), 0);
        check_walk(1'b0);

        finish_run();
    end

endmodule